// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache

This block sits between a processor's byte load/store port and a backing memory that moves whole blocks. Each line keeps a valid flag, a dirty flag, a stored tag and a small data block. Loads and stores that find their line are answered in the cycle they are presented. A store that hits changes only the cached byte and leaves memory stale until that line is replaced. A miss replaces the one line picked by the index. If that line holds modified data, the line is first written out to memory at the address built from its stored tag and index. The block the processor asked for is then read in. A store miss merges its byte into the incoming block and leaves the line dirty.

The processor holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until `cpu_ready` is high for one cycle. On the memory side, `mem_req` stays high with a steady block address, direction and write block until the memory returns a one-cycle `mem_ack`. On a read, `mem_rdata` is valid in that same cycle. Two counters record how many accesses hit and how many missed. With the default parameters the processor address is 4 bits, and there are 4 lines of 2 bytes each.

The controller has four states:
- `ST_LOOKUP` compares the tag and serves hits.
- `ST_WRBACK` writes the dirty victim out to memory.
- `ST_REFILL` reads the missing block in.
- `ST_RESPOND` completes a miss.

The transitions are:
- lookup-miss-dirty: `ST_LOOKUP` to `ST_WRBACK`.
- lookup-miss-clean: `ST_LOOKUP` to `ST_REFILL`.
- writeback-done on ack: `ST_WRBACK` to `ST_REFILL`.
- refill-done on ack: `ST_REFILL` to `ST_RESPOND`.
- respond-done, unconditional: `ST_RESPOND` to `ST_LOOKUP`.

A hit, or a cycle with no request, stays in `ST_LOOKUP`.

Top module: `dm_wb_cache`

## Requirements
- R1: The processor byte address is split as follows: bit 0 picks the byte inside a block, bits 2:1 pick the line, and bit 3 is the tag. Memory block address `mem_addr` = {tag, index}. Inside a block, byte 0 sits in bits 7:0 and byte 1 in bits 15:8. A load of address a returns the current byte at a.
- R2: After reset every line is invalid and clean. Both counters read 0, and `cpu_ready` and `mem_req` are low.
- R3: An access hits when the indexed line is valid and its tag equals the address tag. On a hit, `cpu_ready` is high in the same cycle as the request, `cpu_rdata` is the selected byte, and no memory transaction occurs.
- R4: A store hit writes only the cached byte and marks the line dirty. The backing memory is left unchanged.
- R5: A miss whose victim is invalid or clean issues exactly one memory read of {address tag, index}. `cpu_ready` rises only after that read is acknowledged, and a load then returns the requested byte.
- R6: A store miss reads the block, replaces the addressed byte with `cpu_wdata`, and leaves the line dirty. The merged block reaches memory when the line is later evicted.
- R7: A miss whose victim is valid and dirty first writes the victim block to {victim tag, index}. The read of the new block follows only after that write is acknowledged.
- R8: Each hit adds one to `hit_count` and each miss adds one to `miss_count`, on the first clock edge of the access. The two counters never change together.
- R9: While `mem_req` is high without `mem_ack`, the request, its direction and its block address stay unchanged into the next cycle.
- R10: With `cpu_req` low, `cpu_ready` and `mem_req` stay low and the counters do not move.
- R11: From an empty cache, the access sequence load 1, load 8, store 4, store 13, load 9 yields four misses followed by one hit. The store to 13 writes the byte stored at 4 back to memory address 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | TAG_W+IDX_W+OFF_W | Byte address |
| cpu_wdata | input | BYTE_W | Store byte |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | BYTE_W | Load byte, valid with cpu_ready |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | TAG_W+IDX_W | Block address |
| mem_wdata | output | BYTE_W<<OFF_W | Block written back |
| mem_rdata | input | BYTE_W<<OFF_W | Block read, valid with mem_ack |
| mem_ack | input | 1 | One-cycle transaction acknowledge |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |

## Verification
The hardest case to reach is a miss on a line that is both valid and dirty. It needs an earlier store to bring that exact index into the cache under one tag, and a later access to the same index under the other tag. Only then does the ordered write-then-read pair appear on the memory port.

The bench builds that case on purpose, several times:
- It replays the five-access sequence from R11.
- It dirties a line by a store hit and then evicts it by a load.
- It dirties a line by a store miss and then evicts it.

A behavioural model checks the memory transaction log of each access against its prediction. The model also checks both counters on every clock.

// File: rtl/cache_pkg.sv
package cache_pkg;
    typedef enum logic [1:0] {
        ST_LOOKUP  = 2'd0,
        ST_WRBACK  = 2'd1,
        ST_REFILL  = 2'd2,
        ST_RESPOND = 2'd3
    } cache_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
    parameter int TAG_W = 1,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             alloc_dirty,
    input  logic             dirty_set
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar ln = 0; ln < LINES; ln++) begin : g_line
        wire sel = (rd_idx == IDX_W'(ln));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[ln] <= 1'b0;
                dirty_q[ln] <= 1'b0;
                tag_q[ln]   <= '0;
            end else if (sel && alloc_en) begin
                valid_q[ln] <= 1'b1;
                dirty_q[ln] <= alloc_dirty;
                tag_q[ln]   <= alloc_tag;
            end else if (sel && dirty_set) begin
                dirty_q[ln] <= 1'b1;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 1,
    parameter int BYTE_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [IDX_W-1:0]                idx,
    output logic [(BYTE_W<<OFF_W)-1:0]      rd_block,
    input  logic                            byte_wr,
    input  logic [OFF_W-1:0]                byte_off,
    input  logic [BYTE_W-1:0]               byte_data,
    input  logic                            fill_wr,
    input  logic                            fill_merge,
    input  logic [(BYTE_W<<OFF_W)-1:0]      fill_block
);
    localparam int LINES = 1 << IDX_W;
    localparam int BYTES = 1 << OFF_W;
    localparam int BLK_W = BYTE_W * BYTES;

    logic [BLK_W-1:0] line_q [LINES];

    for (genvar ln = 0; ln < LINES; ln++) begin : g_line
        wire sel = (idx == IDX_W'(ln));
        for (genvar by = 0; by < BYTES; by++) begin : g_byte
            wire hit_byte = (byte_off == OFF_W'(by));
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    line_q[ln][by*BYTE_W +: BYTE_W] <= '0;
                end else if (sel && fill_wr) begin
                    line_q[ln][by*BYTE_W +: BYTE_W] <= (fill_merge && hit_byte)
                        ? byte_data : fill_block[by*BYTE_W +: BYTE_W];
                end else if (sel && byte_wr && hit_byte) begin
                    line_q[ln][by*BYTE_W +: BYTE_W] <= byte_data;
                end
            end
        end
    end

    assign rd_block = line_q[idx];
endmodule

// File: rtl/hit_miss_counter.sv
module hit_miss_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_hit,
    input  logic             inc_miss,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            if (inc_hit)  hit_count  <= hit_count + 1'b1;
            if (inc_miss) miss_count <= miss_count + 1'b1;
        end
    end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_we,
    input  logic line_valid,
    input  logic line_dirty,
    input  logic tag_match,
    input  logic mem_ack,
    output logic cpu_ready,
    output logic mem_req,
    output logic mem_we,
    output logic use_victim,
    output logic byte_wr,
    output logic fill_wr,
    output logic inc_hit,
    output logic inc_miss
);
    cache_state_e state_q, state_d;
    logic hit;

    assign hit = line_valid && tag_match;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP: begin
                if (cpu_req && !hit)
                    state_d = (line_valid && line_dirty) ? ST_WRBACK : ST_REFILL;
            end
            ST_WRBACK:  if (mem_ack) state_d = ST_REFILL;
            ST_REFILL:  if (mem_ack) state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_LOOKUP;
        endcase
    end

    always_comb begin
        cpu_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        use_victim = 1'b0;
        byte_wr    = 1'b0;
        fill_wr    = 1'b0;
        inc_hit    = 1'b0;
        inc_miss   = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                cpu_ready = cpu_req && hit;
                byte_wr   = cpu_req && hit && cpu_we;
                inc_hit   = cpu_req && hit;
                inc_miss  = cpu_req && !hit;
            end
            ST_WRBACK: begin
                mem_req    = 1'b1;
                mem_we     = 1'b1;
                use_victim = 1'b1;
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                fill_wr = mem_ack;
            end
            ST_RESPOND: cpu_ready = 1'b1;
        endcase
    end
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
    parameter int TAG_W  = 1,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 1,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cpu_req,
    input  logic                              cpu_we,
    input  logic [TAG_W+IDX_W+OFF_W-1:0]      cpu_addr,
    input  logic [BYTE_W-1:0]                 cpu_wdata,
    output logic                              cpu_ready,
    output logic [BYTE_W-1:0]                 cpu_rdata,
    output logic                              mem_req,
    output logic                              mem_we,
    output logic [TAG_W+IDX_W-1:0]            mem_addr,
    output logic [(BYTE_W<<OFF_W)-1:0]        mem_wdata,
    input  logic [(BYTE_W<<OFF_W)-1:0]        mem_rdata,
    input  logic                              mem_ack,
    output logic [CNT_W-1:0]                  hit_count,
    output logic [CNT_W-1:0]                  miss_count
);
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W;
    localparam int BLK_W  = BYTE_W << OFF_W;

    logic [TAG_W-1:0] a_tag;
    logic [IDX_W-1:0] a_idx;
    logic [OFF_W-1:0] a_off;
    assign a_off = cpu_addr[OFF_W-1:0];
    assign a_idx = cpu_addr[OFF_W +: IDX_W];
    assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];

    logic             line_valid, line_dirty;
    logic [TAG_W-1:0] line_tag;
    logic [BLK_W-1:0] line_block;
    logic use_victim, byte_wr, fill_wr, inc_hit, inc_miss;

    cache_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .tag_match  (line_tag == a_tag),
        .mem_ack    (mem_ack),
        .cpu_ready  (cpu_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .use_victim (use_victim),
        .byte_wr    (byte_wr),
        .fill_wr    (fill_wr),
        .inc_hit    (inc_hit),
        .inc_miss   (inc_miss)
    );

    cache_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx      (a_idx),
        .rd_valid    (line_valid),
        .rd_dirty    (line_dirty),
        .rd_tag      (line_tag),
        .alloc_en    (fill_wr),
        .alloc_tag   (a_tag),
        .alloc_dirty (cpu_we),
        .dirty_set   (byte_wr)
    );

    cache_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (a_idx),
        .rd_block   (line_block),
        .byte_wr    (byte_wr),
        .byte_off   (a_off),
        .byte_data  (cpu_wdata),
        .fill_wr    (fill_wr),
        .fill_merge (cpu_we),
        .fill_block (mem_rdata)
    );

    hit_miss_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_hit    (inc_hit),
        .inc_miss   (inc_miss),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    assign mem_addr  = use_victim ? {line_tag, a_idx} : {a_tag, a_idx};
    assign mem_wdata = line_block;
    assign cpu_rdata = line_block[a_off*BYTE_W +: BYTE_W];
endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk #(
    parameter int MA_W  = 3,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_req,
    input logic             cpu_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [MA_W-1:0]  mem_addr,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R9

    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we)); // R7

    AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> (!cpu_ready && !mem_req)); // R10

    AST_ONE_COUNTER: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count != $past(hit_count)) |-> $stable(miss_count)); // R8
endmodule

bind dm_wb_cache dm_wb_cache_chk #(.MA_W(TAG_W + IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_ready  (cpu_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/dm_wb_cache_tb_top.sv
`timescale 1ns/1ps
module dm_wb_cache_tb_top;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_ready;
    logic [7:0]  cpu_rdata;
    logic        mem_req, mem_we;
    logic [2:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_ack;
    logic [7:0]  hit_count, miss_count;

    always #5 clk = ~clk;

    dm_wb_cache dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .hit_count(hit_count), .miss_count(miss_count)
    );

    int checks = 0;
    int errors = 0;

    function automatic logic [7:0] init_byte(input int a);
        case (a)
            0: return 8'd78;   1: return 8'd29;   2: return 8'd120;  3: return 8'd123;
            4: return 8'd71;   5: return 8'd150;  6: return 8'd162;  7: return 8'd173;
            8: return 8'd18;   9: return 8'd21;   10: return 8'd33;  11: return 8'd28;
            12: return 8'd19;  13: return 8'd200; 14: return 8'd210; default: return 8'd225;
        endcase
    endfunction

    // Backing memory model with a fixed acknowledge latency and a transaction log.
    logic [7:0] mem [16];
    int         lat_cnt;
    int         log_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            lat_cnt   <= 0;
            for (int i = 0; i < 16; i++) mem[i] <= init_byte(i);
        end else if (mem_req && !mem_ack) begin
            if (lat_cnt == LAT - 1) begin
                mem_ack <= 1'b1;
                lat_cnt <= 0;
                if (mem_we) begin
                    mem[{mem_addr, 1'b0}] <= mem_wdata[7:0];
                    mem[{mem_addr, 1'b1}] <= mem_wdata[15:8];
                    log_q.push_back((1 << 20) | (int'(mem_addr) << 16) | int'(mem_wdata));
                end else begin
                    mem_rdata <= {mem[{mem_addr, 1'b1}], mem[{mem_addr, 1'b0}]};
                    log_q.push_back((int'(mem_addr) << 16) |
                                    (int'(mem[{mem_addr, 1'b1}]) << 8) | int'(mem[{mem_addr, 1'b0}]));
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Behavioural reference model.
    bit   m_valid [4];
    bit   m_dirty [4];
    int   m_tag   [4];
    int   m_data  [4][2];
    int   ref_mem [16];
    int   exp_hits = 0;
    int   exp_misses = 0;
    bit   run_mon = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counter comparison on every clock (R8, R10).
    always @(negedge clk) begin
        if (run_mon) begin
            check(int'(hit_count) == exp_hits, "R8 hit_count", int'(hit_count), exp_hits);
            check(int'(miss_count) == exp_misses, "R8 miss_count", int'(miss_count), exp_misses);
        end
    end

    task automatic access(input bit we, input int a, input int wd);
        int  idx = (a >> 1) & 3;
        int  tg  = (a >> 3) & 1;
        int  off = a & 1;
        bit  hit = m_valid[idx] && (m_tag[idx] == tg);
        bit  vdirty = m_valid[idx] && m_dirty[idx];
        int  exp_log[$];
        int  exp_rd;
        int  got_rd;
        int  waits = 0;
        log_q.delete();
        if (!hit) begin
            if (vdirty) begin
                int vb = (m_tag[idx] << 2) | idx;
                exp_log.push_back((1 << 20) | (vb << 16) | (m_data[idx][1] << 8) | m_data[idx][0]);
                ref_mem[vb*2]   = m_data[idx][0];
                ref_mem[vb*2+1] = m_data[idx][1];
            end
            begin
                int nb = (tg << 2) | idx;
                exp_log.push_back((nb << 16) | (ref_mem[nb*2+1] << 8) | ref_mem[nb*2]);
                m_data[idx][0] = ref_mem[nb*2];
                m_data[idx][1] = ref_mem[nb*2+1];
            end
            m_valid[idx] = 1'b1;
            m_tag[idx]   = tg;
            m_dirty[idx] = 1'b0;
        end
        if (we) begin
            m_data[idx][off] = wd;
            m_dirty[idx] = 1'b1;
        end
        exp_rd = m_data[idx][off];

        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = 4'(a); cpu_wdata = 8'(wd);
        #1;
        check(cpu_ready == hit, hit ? "R3 ready same cycle on hit" : "R5 no ready on miss",
              int'(cpu_ready), int'(hit));
        got_rd = int'(cpu_rdata);
        @(posedge clk); #1;
        if (hit) exp_hits++; else exp_misses++;
        if (!hit) begin
            while (!cpu_ready && waits < 100) begin
                @(negedge clk); #1;
                waits++;
            end
            check(cpu_ready == 1'b1, "R5 miss completes", int'(cpu_ready), 1);
            got_rd = int'(cpu_rdata);
            @(posedge clk); #1;
        end
        cpu_req = 1'b0; cpu_we = 1'b0;
        if (!we) check(got_rd == exp_rd, "R1 load data", got_rd, exp_rd);
        check(log_q.size() == exp_log.size(),
              vdirty && !hit ? "R7 transaction count" : "R5 transaction count",
              log_q.size(), exp_log.size());
        for (int i = 0; i < exp_log.size() && i < log_q.size(); i++)
            check(log_q[i] == exp_log[i], "R7 transaction order and content", log_q[i], exp_log[i]);
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) ref_mem[i] = int'(init_byte(i));
        for (int i = 0; i < 4; i++) begin
            m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_tag[i] = 0;
            m_data[i][0] = 0; m_data[i][1] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check(cpu_ready == 1'b0, "R2 ready low", int'(cpu_ready), 0);
        check(mem_req == 1'b0, "R2 mem_req low", int'(mem_req), 0);
        check(hit_count == 0 && miss_count == 0, "R2 counters zero", int'(hit_count) + int'(miss_count), 0);
        run_mon = 1'b1;

        // R11: the reference sequence, four misses then one hit
        access(1'b0, 1, 0);
        access(1'b0, 8, 0);
        access(1'b1, 4, 18);
        access(1'b1, 13, 29);
        check(miss_count == 4 && hit_count == 0, "R11 four misses", int'(miss_count), 4);
        check(mem[4] == 8'd18, "R11 writeback of store to 4", int'(mem[4]), 18);
        access(1'b0, 9, 0);
        check(hit_count == 1 && miss_count == 4, "R11 final hit", int'(hit_count), 1);

        // R4: store hit leaves memory stale
        access(1'b1, 9, 8'hAB);
        @(negedge clk);
        check(mem[9] == 8'd21, "R4 memory unchanged by store hit", int'(mem[9]), 21);
        access(1'b0, 9, 0);

        // R10: idle cycles with no request
        for (int c = 0; c < 6; c++) begin
            @(negedge clk); #1;
            check(!cpu_ready && !mem_req, "R10 idle quiet", int'(cpu_ready) + int'(mem_req), 0);
        end

        // R7: evict the dirty line at index 0
        access(1'b0, 1, 0);
        @(negedge clk);
        check(mem[9] == 8'hAB, "R7 dirty victim written", int'(mem[9]), 171);

        // R6: store miss on an invalid line, then dirty eviction
        access(1'b1, 6, 8'h5C);
        access(1'b0, 7, 0);
        access(1'b0, 14, 0);
        @(negedge clk);
        check(mem[6] == 8'h5C, "R6 merged store reaches memory", int'(mem[6]), 92);
        check(mem[7] == 8'd173, "R6 neighbour byte preserved", int'(mem[7]), 173);

        // R1: sweep all addresses twice, mixing stores
        for (int p = 0; p < 2; p++)
            for (int a = 0; a < 16; a++) begin
                if (((a + p) % 3) == 0) access(1'b1, a, (a * 17 + p * 5) & 255);
                else                    access(1'b0, a, 0);
            end

        // Flush every line by touching the opposite tag, then compare memory.
        for (int i = 0; i < 4; i++) access(1'b0, ((m_tag[i] ^ 1) << 3) | (i << 1), 0);
        @(negedge clk);
        for (int a = 0; a < 16; a++)
            if (!(m_valid[(a >> 1) & 3] && m_tag[(a >> 1) & 3] == ((a >> 3) & 1) && m_dirty[(a >> 1) & 3]))
                check(int'(mem[a]) == ref_mem[a], "R6 final memory image", int'(mem[a]), ref_mem[a]);

        run_mon = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule